// File: doc/BRIEF.md
# Serial Channel Diagnostic Loopback Router

This block sits between the four pins of a bit-serial line port and the port's internal transmitter and receiver. The pins are data in, data out, receive bit clock and transmit bit clock. A two-bit mode value picks one of four routings. Normal operation passes both directions straight through. Automatic echo sends every received bit back out while the host still receives. Local loopback turns the transmitter back into the receiver inside the block and holds the line idle. Remote loopback returns line data to the far end and gives the host neither direction. In each routing the block chooses which bit clock times the receiver and the outgoing data. It also decides whether host writes to the transmit register are accepted and whether assembled receive words reach the host.

The serial bit clocks are slow level inputs. They are sampled by the system clock, and a rising edge on either one is a bit event. A simple shift-register transmitter and receiver are part of the block so that each routing can be exercised end to end. A frame timer, counted from the system clock, gives a periodic frame pulse. At each pulse the block flags a transmit underrun and a receive overrun for the channel data registers. Mode changes wait for a frame pulse, so a routing never switches in the middle of a word.

Top module: `serial_loop_router`

## Requirements
- R1: After reset the active mode is 00, ser_dout is 1, stat_o is 000, rx_full_o is 0 and rx_rdata is all zeros.
- R2: A write on mode_wr is held pending and becomes the active mode (mode_o) only at the clock edge that ends a frame (the cycle frame_irq is 1). A change of mode also restarts the receiver's bit count. Encoding: 00 normal, 01 automatic echo, 10 local loopback, 11 remote loopback.
- R3: In normal mode an accepted write loads the transmit register. ser_dout shows its most significant bit, and each rising edge of ser_txclk shifts it out most-significant bit first, filling with 1. Each rising edge of ser_rxclk shifts ser_din into the receiver. After DATA_W bits the word is copied to rx_rdata and rx_full_o is set, and a pulse on rx_rd clears rx_full_o.
- R4: In automatic echo mode, each rising edge of ser_rxclk captures ser_din onto ser_dout. The receiver keeps assembling words for the host from ser_din on ser_rxclk, and edges of ser_txclk do not change ser_dout.
- R5: In local loopback mode ser_dout is held at 1. The receiver takes the transmitter's serial output, one bit on each rising edge of ser_txclk. ser_din and ser_rxclk have no effect on the receiver.
- R6: In remote loopback mode ser_dout follows ser_din captured on rising edges of ser_rxclk. Words received in this mode are not delivered: rx_rdata and rx_full_o do not change.
- R7: In automatic echo and remote loopback modes, tx_wr is ignored. The transmit register keeps its content, and the write does not count as a write for underrun.
- R8: frame_irq is a one-cycle pulse every FRAME_DIV system clocks, and each pulse sets stat_o bit 0.
- R9: At each frame pulse, stat_o bit 1 (underrun) is set if no write was accepted during the frame that is ending.
- R10: At each frame pulse, stat_o bit 2 (overrun) is set if rx_full_o is still 1.
- R11: stat_o bits are sticky. A pulse on stat_clr clears exactly the bits that are 1 in stat_clr_mask, and a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_wr | input | 1 | Strobe for a new pending mode |
| mode_wdata | input | 2 | Requested mode |
| mode_o | output | 2 | Active mode |
| ser_din | input | 1 | Serial line data in |
| ser_dout | output | 1 | Serial line data out |
| ser_rxclk | input | 1 | Receive bit clock, rising edge active |
| ser_txclk | input | 1 | Transmit bit clock, rising edge active |
| tx_wr | input | 1 | Host write to the transmit register |
| tx_wdata | input | DATA_W | Host transmit word |
| rx_rd | input | 1 | Host read of the receive register |
| rx_rdata | output | DATA_W | Last delivered receive word |
| rx_full_o | output | 1 | Receive register holds an unread word |
| frame_irq | output | 1 | Frame interrupt pulse |
| stat_o | output | 3 | Sticky status: bit 2 overrun, bit 1 underrun, bit 0 frame |
| stat_clr | input | 1 | Clear strobe for status |
| stat_clr_mask | input | 3 | Status bits to clear |

## Verification
A wrong routing shows on ser_dout at the very next serial bit event. A wrong clock source shows as a receiver that either moves with the other bit clock or does not move with its own, and this is seen on rx_full_o after one word of bit events. A slipped bit count or a wrong receive input shows as a wrong word on rx_rdata when the DATA_W-th bit arrives. The exhaustive local loopback sweep of every word value exposes any bit-order or fill error. Errors in the mode timing, the underrun and overrun accounting, or the sticky clearing first appear in stat_o and mode_o at the frame edge that follows, at most FRAME_DIV cycles later.

// File: rtl/slr_pkg.sv
package slr_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_ECHO   = 2'b01,
        MODE_LOCAL  = 2'b10,
        MODE_REMOTE = 2'b11
    } slr_mode_e;

    localparam int ST_FRAME = 0;
    localparam int ST_UNDER = 1;
    localparam int ST_OVER  = 2;
    localparam int ST_W     = 3;
endpackage

// File: rtl/slr_frame_timer.sv
module slr_frame_timer #(
    parameter int FRAME_DIV = 33000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (FRAME_DIV > 1) ? $clog2(FRAME_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(FRAME_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = (st_q.cnt == LAST);
endmodule

// File: rtl/slr_tx_ser.sv
module slr_tx_ser #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              sout
);
    typedef struct packed {
        logic [DATA_W-1:0] sr;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)       st_d.sr = load_data;
        else if (shift) st_d.sr = {st_q.sr[DATA_W-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sr: '1};
        else        st_q <= st_d;
    end

    assign sout = st_q.sr[DATA_W-1];
endmodule

// File: rtl/slr_rx_des.sv
module slr_rx_des #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic              sin,
    input  logic              deliver_en,
    input  logic              rd,
    input  logic              restart,
    output logic [DATA_W-1:0] rdata,
    output logic              full
);
    localparam int CW = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] hold;
        logic              full;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic [DATA_W-1:0] sr_next;

    always_comb begin
        st_d    = st_q;
        sr_next = {st_q.sr[DATA_W-2:0], sin};
        if (rd) st_d.full = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (shift) begin
            st_d.sr = sr_next;
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                if (deliver_en) begin
                    st_d.hold = sr_next;
                    st_d.full = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.hold;
    assign full  = st_q.full;
endmodule

// File: rtl/serial_loop_router.sv
module serial_loop_router
    import slr_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int FRAME_DIV = 33000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [1:0]        mode_wdata,
    output logic [1:0]        mode_o,
    input  logic              ser_din,
    output logic              ser_dout,
    input  logic              ser_rxclk,
    input  logic              ser_txclk,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              rx_full_o,
    output logic              frame_irq,
    output logic [ST_W-1:0]   stat_o,
    input  logic              stat_clr,
    input  logic [ST_W-1:0]   stat_clr_mask
);
    typedef struct packed {
        slr_mode_e       mode;
        slr_mode_e       pend;
        logic            rxc;
        logic            txc;
        logic            echo;
        logic            seen;
        logic [ST_W-1:0] stat;
    } top_st_t;

    top_st_t st_d, st_q;

    logic tick, rx_e, tx_e, host_tx_ok, tx_load, tx_shift;
    logic rx_shift, rx_sin, deliver, mode_chg, tx_sout, rx_full;

    slr_frame_timer #(.FRAME_DIV(FRAME_DIV)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    slr_tx_ser #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .load_data(tx_wdata),
        .shift(tx_shift), .sout(tx_sout)
    );

    slr_rx_des #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .shift(rx_shift), .sin(rx_sin),
        .deliver_en(deliver), .rd(rx_rd), .restart(mode_chg),
        .rdata(rx_rdata), .full(rx_full)
    );

    // Routing for the active mode.
    always_comb begin
        rx_e       = ser_rxclk & ~st_q.rxc;
        tx_e       = ser_txclk & ~st_q.txc;
        host_tx_ok = (st_q.mode == MODE_NORMAL) || (st_q.mode == MODE_LOCAL);
        tx_load    = tx_wr & host_tx_ok;
        tx_shift   = tx_e & host_tx_ok;
        deliver    = (st_q.mode != MODE_REMOTE);
        if (st_q.mode == MODE_LOCAL) begin
            rx_shift = tx_e;
            rx_sin   = tx_sout;
        end else begin
            rx_shift = rx_e;
            rx_sin   = ser_din;
        end
        case (st_q.mode)
            MODE_NORMAL: ser_dout = tx_sout;
            MODE_LOCAL:  ser_dout = 1'b1;
            default:     ser_dout = st_q.echo;
        endcase
        mode_chg = tick && (st_q.pend != st_q.mode);
    end

    // Next state of mode, edge history, echo bit and status.
    always_comb begin
        st_d      = st_q;
        st_d.rxc  = ser_rxclk;
        st_d.txc  = ser_txclk;
        if (rx_e) st_d.echo = ser_din;
        if (mode_wr) st_d.pend = slr_mode_e'(mode_wdata);
        st_d.seen = st_q.seen | tx_load;
        if (stat_clr) st_d.stat = st_q.stat & ~stat_clr_mask;
        if (tick) begin
            st_d.mode           = st_q.pend;
            st_d.seen           = 1'b0;
            st_d.stat[ST_FRAME] = 1'b1;
            if (!(st_q.seen || tx_load)) st_d.stat[ST_UNDER] = 1'b1;
            if (rx_full)                 st_d.stat[ST_OVER]  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_NORMAL, pend: MODE_NORMAL, rxc: 1'b0,
                      txc: 1'b0, echo: 1'b1, seen: 1'b0, stat: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.mode;
    assign rx_full_o = rx_full;
    assign frame_irq = tick;
    assign stat_o    = st_q.stat;
endmodule

// File: rtl/slr_checker.sv
module slr_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_o,
    input logic              ser_din,
    input logic              ser_dout,
    input logic              ser_rxclk,
    input logic [DATA_W-1:0] rx_rdata,
    input logic              rx_full_o,
    input logic              frame_irq,
    input logic [2:0]        stat_o,
    input logic              stat_clr,
    input logic [2:0]        stat_clr_mask
);
    logic [2:0] keep;
    assign keep = stat_o & ~({3{stat_clr}} & stat_clr_mask);

    // R2: active mode moves only on a frame edge
    a_r2_mode_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_irq |=> $stable(mode_o));

    // R8: frame pulse lasts one cycle
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq |=> !frame_irq);

    // R5: line idles at 1 in local loopback
    a_r5_local_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |-> ser_dout);

    // R4 and R6: returned bit equals the one sampled at the receive edge
    a_r4_echo_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 2'b01 || mode_o == 2'b11) && $rose(ser_rxclk) && !frame_irq)
        |=> (ser_dout == $past(ser_din)));

    // R6: nothing delivered to the host in remote loopback
    a_r6_no_deliver: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11 && !rx_full_o && !frame_irq)
        |=> (!rx_full_o && $stable(rx_rdata)));

    // R11: bits not being cleared stay set
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(keep)) == $past(keep)));
endmodule

bind serial_loop_router slr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .ser_din(ser_din),
    .ser_dout(ser_dout), .ser_rxclk(ser_rxclk), .rx_rdata(rx_rdata),
    .rx_full_o(rx_full_o), .frame_irq(frame_irq), .stat_o(stat_o),
    .stat_clr(stat_clr), .stat_clr_mask(stat_clr_mask)
);

// File: tb/serial_loop_router_tb.sv
`timescale 1ns/1ps
module serial_loop_router_tb;
    localparam int W   = 8;
    localparam int DIV = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_wr = 1'b0;
    logic [1:0] mode_wdata = 2'b00;
    logic [1:0] mode_o;
    logic ser_din = 1'b0, ser_dout, ser_rxclk = 1'b0, ser_txclk = 1'b0;
    logic tx_wr = 1'b0;
    logic [W-1:0] tx_wdata = '0;
    logic rx_rd = 1'b0;
    logic [W-1:0] rx_rdata;
    logic rx_full_o, frame_irq;
    logic [2:0] stat_o;
    logic stat_clr = 1'b0;
    logic [2:0] stat_clr_mask = 3'b000;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serial_loop_router #(.DATA_W(W), .FRAME_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .mode_o(mode_o), .ser_din(ser_din), .ser_dout(ser_dout),
        .ser_rxclk(ser_rxclk), .ser_txclk(ser_txclk), .tx_wr(tx_wr),
        .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .rx_full_o(rx_full_o), .frame_irq(frame_irq), .stat_o(stat_o),
        .stat_clr(stat_clr), .stat_clr_mask(stat_clr_mask)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_rx(input logic b);
        @(negedge clk); ser_din = b; ser_rxclk = 1'b1;
        @(negedge clk); ser_rxclk = 1'b0;
    endtask

    task automatic pulse_tx();
        @(negedge clk); ser_txclk = 1'b1;
        @(negedge clk); ser_txclk = 1'b0;
    endtask

    task automatic host_write(input logic [W-1:0] d);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = d;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic clr_stat(input logic [2:0] m);
        @(negedge clk); stat_clr = 1'b1; stat_clr_mask = m;
        @(negedge clk); stat_clr = 1'b0; stat_clr_mask = 3'b000;
    endtask

    task automatic wait_frame();
        do @(negedge clk); while (!frame_irq);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        logic [1:0] old;
        old = mode_o;
        @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
        @(negedge clk); mode_wr = 1'b0;
        check("R2 mode held until frame", {30'd0, mode_o}, {30'd0, old});
        wait_frame();
        check("R2 mode applied at frame", {30'd0, mode_o}, {30'd0, m});
    endtask

    initial begin
        #(4 * 150000);
        $display("FAIL watchdog: actual timeout expected completion");
        n_chk++; n_bad++;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] wd;
        int gap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 dout", {31'd0, ser_dout}, 32'd1);
        check("R1 mode", {30'd0, mode_o}, 32'd0);
        check("R1 stat", {29'd0, stat_o}, 32'd0);
        check("R1 rx_full", {31'd0, rx_full_o}, 32'd0);
        check("R1 rdata", {24'd0, rx_rdata}, 32'd0);

        // R8 period and pulse width
        do @(negedge clk); while (!frame_irq);
        gap = 0;
        @(negedge clk);
        check("R8 pulse one cycle", {31'd0, frame_irq}, 32'd0);
        check("R8 frame bit set", {31'd0, stat_o[0]}, 32'd1);
        gap = 1;
        while (!frame_irq) begin @(negedge clk); gap++; end
        check("R8 period", gap, DIV);

        // R3 normal transmit, MSB first, fill with 1
        wd = 8'hA5;
        host_write(wd);
        check("R3 tx first bit", {31'd0, ser_dout}, {31'd0, wd[7]});
        for (int i = 6; i >= 0; i--) begin
            pulse_tx();
            check("R3 tx bit", {31'd0, ser_dout}, {31'd0, wd[i]});
        end
        pulse_tx();
        check("R3 tx fill", {31'd0, ser_dout}, 32'd1);

        // R3 normal receive
        wd = 8'h3C;
        for (int i = 7; i >= 0; i--) begin
            if (i == 0) check("R3 not full early", {31'd0, rx_full_o}, 32'd0);
            pulse_rx(wd[i]);
        end
        check("R3 rx word", {24'd0, rx_rdata}, {24'd0, wd});
        check("R3 rx full", {31'd0, rx_full_o}, 32'd1);
        host_read();
        check("R3 read clears full", {31'd0, rx_full_o}, 32'd0);

        // R9 write during frame: no underrun
        wait_frame(); clr_stat(3'b111);
        host_write(8'hFF);
        wait_frame();
        check("R9 no underrun after write", {29'd0, stat_o}, 32'd1);
        // R9 no write: underrun
        clr_stat(3'b111);
        wait_frame();
        check("R9 underrun", {29'd0, stat_o}, 32'd3);
        // R10 unread word: overrun
        clr_stat(3'b111);
        for (int i = 7; i >= 0; i--) pulse_rx(i[0]);
        wait_frame();
        check("R10 overrun", {29'd0, stat_o}, 32'd7);
        // R11 masked clear
        clr_stat(3'b100);
        check("R11 masked clear", {29'd0, stat_o}, 32'd3);
        host_read();

        // R4 automatic echo
        set_mode(2'b01);
        wd = 8'h96;
        for (int i = 7; i >= 0; i--) begin
            pulse_rx(wd[i]);
            check("R4 echo bit", {31'd0, ser_dout}, {31'd0, wd[i]});
        end
        check("R4 host still receives", {24'd0, rx_rdata}, {24'd0, wd});
        check("R4 rx full", {31'd0, rx_full_o}, 32'd1);
        host_read();
        pulse_tx();
        check("R4 tx clock no effect", {31'd0, ser_dout}, {31'd0, wd[0]});
        // R7 ignored write still underruns
        wait_frame(); clr_stat(3'b111);
        host_write(8'h00);
        wait_frame();
        check("R7 ignored write underruns", {30'd0, stat_o[1:0]}, 32'd3);

        // R6 remote loopback
        set_mode(2'b11);
        wd = 8'h5A;
        for (int i = 7; i >= 0; i--) begin
            pulse_rx(wd[i]);
            check("R6 remote echo bit", {31'd0, ser_dout}, {31'd0, wd[i]});
        end
        check("R6 not delivered full", {31'd0, rx_full_o}, 32'd0);
        check("R6 not delivered data", {24'd0, rx_rdata}, 32'h96);
        host_write(8'h00);

        // R5 local loopback
        set_mode(2'b10);
        check("R5 idle dout", {31'd0, ser_dout}, 32'd1);
        for (int i = 0; i < 16; i++) pulse_rx(i[0]);
        check("R5 din ignored full", {31'd0, rx_full_o}, 32'd0);
        check("R5 din ignored data", {24'd0, rx_rdata}, 32'h96);
        // R7 transmit register untouched by ignored writes
        for (int i = 0; i < 8; i++) pulse_tx();
        check("R7 tx kept all ones", {24'd0, rx_rdata}, 32'hFF);
        host_read();
        // R5 exhaustive word sweep
        for (int v = 0; v < 256; v++) begin
            host_write(v[7:0]);
            for (int i = 0; i < 8; i++) pulse_tx();
            check("R5 loop word", {24'd0, rx_rdata}, v);
            check("R5 loop full", {31'd0, rx_full_o}, 32'd1);
            check("R5 dout idle", {31'd0, ser_dout}, 32'd1);
            host_read();
        end

        set_mode(2'b00);
        check("R3 back to normal idle", {31'd0, ser_dout}, 32'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule